// File: doc/BRIEF.md
# Guarded Greatest-Common-Divisor Unit

This block computes the greatest common divisor of two unsigned operands. It uses a subtract-or-swap recurrence that advances one step per clock cycle. Two requests reach it through guarded handshakes: one loads a new operand pair, the other collects the answer. Each request has a ready output and an enable input. The caller raises an enable only in a cycle where the matching ready is high, so the guard itself says when a request applies and no separate status flag is needed.

A request to start loads the two working registers and marks the unit busy. While busy, the unit repeats one step per cycle. When the first working register holds a value no smaller than the second, it subtracts the second from it. Otherwise, if the first register is nonzero, the two registers swap contents. The answer is ready once the first register reaches zero, and the second register then holds the divisor. Collecting the answer frees the unit for the next pair. The second operand must be nonzero; a zero second operand is outside the contract.

Top module: `gcd_guarded_unit`

## Requirements
- R1: After reset, startRdy is 1, resultRdy is 0 and resultData is 0, because both working registers clear to zero and the unit is idle.
- R2: startRdy is high exactly when the unit is idle. A clock edge with startEn and startRdy both high loads startA and startB and makes the unit busy, so startRdy is 0 in the following cycle.
- R3: startEn asserted while startRdy is 0 is ignored: the operand pair in progress is not replaced and the unit stays busy.
- R4: One recurrence step happens per busy cycle while the first register is nonzero. With a first operand of zero, resultRdy is high in the cycle right after the accepting edge. With equal nonzero operands, resultRdy is high two cycles after that edge.
- R5: resultRdy is high only while the unit is busy and the first working register is zero. It is never high before the first accepted start.
- R6: When resultRdy is high, resultData equals the greatest common divisor of the accepted operands, for any second operand that is nonzero.
- R7: A clock edge with resultEn and resultRdy both high frees the unit, so in the next cycle startRdy is 1 and resultRdy is 0.
- R8: resultEn asserted while resultRdy is 0 is ignored and does not free the unit or disturb the computation.
- R9: While the first register is zero and no start is being accepted, resultData holds steady from cycle to cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| startEn | input | 1 | Start request enable |
| startA | input | WIDTH | First operand |
| startB | input | WIDTH | Second operand, must be nonzero |
| startRdy | output | 1 | Start request may be issued |
| resultEn | input | 1 | Result collection enable |
| resultData | output | WIDTH | Computed divisor, valid while resultRdy is high |
| resultRdy | output | 1 | Result may be collected |

## Verification
On every cycle, assertions check the guard relations: an accepted start drops startRdy, and an ignored start leaves the unit busy. They also check that collecting a result frees the unit, that resultRdy is never high while idle, that each subtract step lowers the first register, and that the answer holds still while it waits. Only the bench scenarios can show that the final value is the correct divisor for each operand pair. The same goes for the exact latency of the short cases, and for the fact that a start or collect request raised while not ready leaves the pending answer unchanged. The bench runs every pair with a first operand from 0 to 23 and a second operand from 1 to 23, plus several wide 32-bit pairs built from large common factors.

// File: rtl/gcd_pkg.sv
package gcd_pkg;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic load;   // capture a fresh operand pair
    logic step;   // advance the recurrence by one step
  } ctrlStrobes_t;

endpackage

// File: rtl/gcd_dpath.sv
module gcd_dpath #(
  parameter int WIDTH = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  gcd_pkg::ctrlStrobes_t strobes,
  input  logic [WIDTH-1:0]      opA,
  input  logic [WIDTH-1:0]      opB,
  output logic                  xZero,
  output logic [WIDTH-1:0]      yOut
);

  logic [WIDTH-1:0] xReg;
  logic [WIDTH-1:0] yReg;
  logic [WIDTH-1:0] xNext;
  logic [WIDTH-1:0] yNext;
  logic             xGeY;

  assign xGeY = (xReg >= yReg);

  always_comb begin
    xNext = xReg;
    yNext = yReg;
    if (strobes.load) begin
      xNext = opA;
      yNext = opB;
    end else if (strobes.step) begin
      if (xGeY) begin
        xNext = xReg - yReg;
      end else begin
        xNext = yReg;
        yNext = xReg;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xReg <= '0;
      yReg <= '0;
    end else begin
      xReg <= xNext;
      yReg <= yNext;
    end
  end

  assign xZero = (xReg == '0);
  assign yOut  = yReg;

  // R4
  subtract_shrinks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.step && !strobes.load && xGeY && (yReg != '0)) |=> (xReg < $past(xReg)));

  // R9
  answer_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (xZero && !strobes.load) |=> (xZero && $stable(yReg)));

endmodule

// File: rtl/gcd_ctrl.sv
module gcd_ctrl (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  startEn,
  input  logic                  resultEn,
  input  logic                  xZero,
  output logic                  startRdy,
  output logic                  resultRdy,
  output gcd_pkg::ctrlStrobes_t strobes
);

  logic busy;
  logic startFire;
  logic resultFire;

  assign startRdy   = !busy;
  assign resultRdy  = busy && xZero;
  assign startFire  = startEn && startRdy;
  assign resultFire = resultEn && resultRdy;

  always_comb begin
    strobes      = '0;
    strobes.load = startFire;
    strobes.step = busy && !xZero;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
    end else if (startFire) begin
      busy <= 1'b1;
    end else if (resultFire) begin
      busy <= 1'b0;
    end
  end

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startEn && startRdy) |=> !startRdy);

  // R3
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startEn && !startRdy && !(resultEn && resultRdy)) |=> !startRdy);

  // R5
  result_needs_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultRdy |-> !startRdy);

  // R7
  result_frees_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resultEn && resultRdy) |=> (startRdy && !resultRdy));

  // R8
  result_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resultEn && !resultRdy && !startRdy) |=> !startRdy);

endmodule

// File: rtl/gcd_guarded_unit.sv
module gcd_guarded_unit #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startEn,
  input  logic [WIDTH-1:0] startA,
  input  logic [WIDTH-1:0] startB,
  output logic             startRdy,
  input  logic             resultEn,
  output logic [WIDTH-1:0] resultData,
  output logic             resultRdy
);

  gcd_pkg::ctrlStrobes_t strobes;
  logic                  xZero;

  gcd_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .startEn   (startEn),
    .resultEn  (resultEn),
    .xZero     (xZero),
    .startRdy  (startRdy),
    .resultRdy (resultRdy),
    .strobes   (strobes)
  );

  gcd_dpath #(.WIDTH(WIDTH)) dpath_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .opA     (startA),
    .opB     (startB),
    .xZero   (xZero),
    .yOut    (resultData)
  );

endmodule

// File: tb/gcd_guarded_unit_tb.sv
module gcd_guarded_unit_tb_top;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rstN;
  logic         startEn;
  logic [W-1:0] startA;
  logic [W-1:0] startB;
  logic         startRdy;
  logic         resultEn;
  logic [W-1:0] resultData;
  logic         resultRdy;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  gcd_guarded_unit #(.WIDTH(W)) dut_i (
    .clk(clk), .rstN(rstN), .startEn(startEn), .startA(startA), .startB(startB),
    .startRdy(startRdy), .resultEn(resultEn), .resultData(resultData), .resultRdy(resultRdy)
  );

  function automatic logic [W-1:0] refGcd(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] p = a;
    logic [W-1:0] q = b;
    logic [W-1:0] t;
    while (q != 0) begin
      t = p % q;
      p = q;
      q = t;
    end
    return p;
  endfunction

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // start, try an ignored start, wait, compare, collect
  task automatic runPair(input logic [W-1:0] a, input logic [W-1:0] b);
    int cnt = 0;
    startA = a; startB = b; startEn = 1'b1;
    @(negedge clk);
    startEn = 1'b0;
    check(startRdy == 1'b0, "R2 busy after start", W'(startRdy), 0);
    startA = ~a; startB = b + 1; startEn = 1'b1;   // R3 refused while busy
    @(negedge clk);
    startEn = 1'b0;
    while (!resultRdy && cnt < 2000) begin
      @(negedge clk);
      cnt++;
    end
    check(resultRdy == 1'b1, "R5 result ready in time", W'(resultRdy), 1);
    check(resultData == refGcd(a, b), "R6 R3 divisor", resultData, refGcd(a, b));
    resultEn = 1'b1;
    @(negedge clk);
    resultEn = 1'b0;
    check(startRdy == 1'b1 && resultRdy == 1'b0, "R7 freed", W'({startRdy, resultRdy}), 2);
  endtask

  initial begin
    #(20 * 190000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; startEn = 1'b0; resultEn = 1'b0; startA = '0; startB = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    check(startRdy == 1'b1, "R1 startRdy", W'(startRdy), 1);
    check(resultRdy == 1'b0, "R1 resultRdy", W'(resultRdy), 0);
    check(resultData == '0, "R1 resultData", resultData, 0);

    // R8, R5: collect before any start
    resultEn = 1'b1;
    @(negedge clk);
    resultEn = 1'b0;
    check(startRdy == 1'b1 && resultRdy == 1'b0, "R8 R5 early collect ignored", W'({startRdy, resultRdy}), 2);

    // R4: zero first operand gives answer right after the accepting edge
    startA = 0; startB = 7; startEn = 1'b1;
    @(negedge clk);
    startEn = 1'b0;
    check(resultRdy == 1'b1, "R4 zero-a latency", W'(resultRdy), 1);
    check(resultData == 7, "R6 zero-a value", resultData, 7);
    check(startRdy == 1'b0, "R2 busy", W'(startRdy), 0);
    // R3: start while busy leaves the pending answer
    startA = 9; startB = 3; startEn = 1'b1;
    @(negedge clk);
    startEn = 1'b0;
    check(resultRdy == 1'b1 && resultData == 7, "R3 R9 answer kept", resultData, 7);
    resultEn = 1'b1;
    @(negedge clk);
    resultEn = 1'b0;
    check(startRdy == 1'b1 && resultRdy == 1'b0, "R7 freed", W'({startRdy, resultRdy}), 2);

    // R4: equal operands, ready two cycles after accept; R8 collect while not ready
    startA = 12; startB = 12; startEn = 1'b1;
    @(negedge clk);
    startEn = 1'b0;
    check(resultRdy == 1'b0, "R4 equal not yet", W'(resultRdy), 0);
    resultEn = 1'b1;
    @(negedge clk);
    resultEn = 1'b0;
    check(resultRdy == 1'b1 && resultData == 12, "R4 R8 equal ready", resultData, 12);
    check(startRdy == 1'b0, "R8 still busy", W'(startRdy), 0);
    resultEn = 1'b1;
    @(negedge clk);
    resultEn = 1'b0;

    // R6 sweep
    for (int a = 0; a < 24; a++) begin
      for (int b = 1; b < 24; b++) begin
        runPair(W'(a), W'(b));
      end
    end

    // R6 wide operands with large common factors
    runPair(32'h5000_000F, 32'h3000_0009);
    runPair(32'hFFFF_FFFF, 32'h5555_5555);
    runPair(32'hE000_0000, 32'h2000_0000);
    runPair(32'h0700_0007, 32'h0B00_000B);

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule